// File: doc/BRIEF.md
# Control Register Write Handler

This block keeps the processor's paging and mode control registers (the machine control word CR0, the page-table base CR3, the feature control word CR4 and the extended-feature enable register) together with a small vector of hidden mode flags derived from them. A write request carries a selector and 32 bits of data. Writes to CR0 and CR4 are not plain stores. A CR0 write can switch long mode on or off, always has the ET bit forced on, and recomputes the protected-mode, segment-add and FPU flags. A CR4 write masks out the fast-save enable bit when streaming SIMD is not built in. Any write that changes a bit the address translator depends on raises a one-cycle request to flush the translation cache.

An attempt to enter long mode while physical address extension is off is rejected. Nothing is stored, and the block raises a one-cycle fault indication for the exception logic to act on. Leaving long mode raises a one-cycle pulse that tells the fetch logic to cut the instruction pointer down to its low 32 bits. The segment loader reports two of the hidden flags through its own update strobe: 64-bit code and segment-base addition. Reset loads CR0 through the same update logic that a normal write uses.

Top module: `ctl_reg_unit`

## Requirements
- R1: After reset cr0_o = 0x60000010, cr3_o = cr4_o = efer_o = 0, hflags_o = 0x02 (only ADDSEG set), and tlb_flush_o, lm_fault_o and ip_trunc_o are low.
- R2: With wr_en high, wr_sel selects the target (0 = CR0, 1 = CR3, 2 = CR4, 3 = extended-feature enable), and the new value is visible on the outputs from the clock edge that samples the strobe.
- R3: A stored CR0 always has bit 4 (ET) set, whatever the written data holds.
- R4: An accepted CR0 write whose data differs from the old CR0 in bit 31 (PG), bit 16 (WP) or bit 0 (PE) raises tlb_flush_o. A CR0 write that differs in none of these does not raise it.
- R5: A CR0 write that takes PG from 0 to 1 while the LME bit (bit 8 of the enable register) is set, and CR4 bit 5 (PAE) is set, sets LMA. LMA shows both as efer_o bit 10 and as hflags_o bit 5.
- R6: The same transition with CR4.PAE clear is rejected. CR0, LMA and all hidden flags stay as they were, lm_fault_o pulses, and tlb_flush_o stays low.
- R7: A CR0 write that takes PG from 1 to 0 while LMA is set clears LMA, clears the 64-bit code flag (hflags_o bit 6) and pulses ip_trunc_o.
- R8: hflags_o bit 0 (PE) follows CR0 bit 0. Every accepted CR0 write with PE = 0 sets hflags_o bit 1 (ADDSEG).
- R9: Each accepted CR0 write copies CR0 bits 1, 2 and 3 into hflags_o bits 2 (MP), 3 (EM) and 4 (TS).
- R10: A CR4 write that changes bit 7 (PGE), bit 5 (PAE) or bit 4 (PSE) raises tlb_flush_o. When SSE_EN is 0, CR4 bit 9 (OSFXSR) is stored as 0. hflags_o bit 7 follows the stored CR4 bit 9.
- R11: A CR3 write stores the data and raises tlb_flush_o only if CR0.PG is set.
- R12: tlb_flush_o, lm_fault_o and ip_trunc_o are high only in the cycle after the write that caused them, and are low after a cycle without a write.
- R13: A segment-loader update (seg_upd) sets the 64-bit code flag from seg_cs64 only while LMA is set. It sets ADDSEG from seg_addseg only while PE is set. Otherwise it has no effect on these flags. It is applied before a CR0 write in the same cycle.
- R14: A write to the extended-feature enable register changes only LME (bit 8). LMA (bit 10) is not writable there, and every other bit of efer_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register selector |
| wr_data | input | 32 | Write data |
| seg_upd | input | 1 | Segment loader flag update strobe |
| seg_cs64 | input | 1 | New 64-bit code flag from the segment loader |
| seg_addseg | input | 1 | New segment-add flag from the segment loader |
| cr0_o | output | 32 | Stored CR0 |
| cr3_o | output | 32 | Stored CR3 |
| cr4_o | output | 32 | Stored CR4 |
| efer_o | output | 32 | Extended-feature enable register (LME bit 8, LMA bit 10) |
| hflags_o | output | 8 | Hidden mode flags: PE, ADDSEG, MP, EM, TS, LMA, CS64, OSFXSR from bit 0 up |
| tlb_flush_o | output | 1 | One-cycle translation cache flush request |
| lm_fault_o | output | 1 | One-cycle rejected long-mode entry indication |
| ip_trunc_o | output | 1 | One-cycle instruction pointer truncation request |

## Verification
All derived state sits on the ports, so a wrong internal value is visible in the cycle right after the write that produced it. A hidden flag that has drifted from CR0 or CR4, or an LMA bit that disagrees between efer_o and hflags_o, shows on the very next output sample. Errors in the transition rules are harder to see. A wrong old-versus-new comparison shows only as a missing or extra flush, fault or truncation pulse in that one cycle, so the bench compares every output against a model after every cycle. It drives long-mode entry, rejection and exit in a fixed order, and then a long random run of mixed writes and segment updates.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;

    localparam int REG_W    = 32;
    localparam int SEL_W    = 2;
    localparam int HFLAG_W  = 8;

    // CR0 bit positions
    localparam int CR0_PE   = 0;
    localparam int CR0_MP   = 1;
    localparam int CR0_TS   = 3;
    localparam int CR0_ET   = 4;
    localparam int CR0_WP   = 16;
    localparam int CR0_PG   = 31;

    // CR4 bit positions
    localparam int CR4_PSE  = 4;
    localparam int CR4_PAE  = 5;
    localparam int CR4_PGE  = 7;
    localparam int CR4_FXS  = 9;

    // extended-feature enable bit positions
    localparam int EXT_LME  = 8;
    localparam int EXT_LMA  = 10;

    localparam logic [REG_W-1:0] CR0_RESET = 32'h6000_0010;

    typedef enum logic [SEL_W-1:0] {
        SEL_CR0 = 2'd0,
        SEL_CR3 = 2'd1,
        SEL_CR4 = 2'd2,
        SEL_EXT = 2'd3
    } reg_sel_e;

    // packed from bit 7 down to bit 0
    typedef struct packed {
        logic osfxsr;
        logic cs64;
        logic lma;
        logic ts;
        logic em;
        logic mp;
        logic addseg;
        logic pe;
    } hflags_t;

    typedef struct packed {
        logic [REG_W-1:0] cr0;
        logic [REG_W-1:0] cr3;
        logic [REG_W-1:0] cr4;
        logic             lme;
        hflags_t          hf;
    } ctl_state_t;

    typedef struct packed {
        logic flush;
        logic fault;
        logic trunc;
    } ctl_pulse_t;

endpackage

// File: rtl/ctl_cr0_update.sv
module ctl_cr0_update
    import ctl_reg_pkg::*;
(
    input  logic [REG_W-1:0] cur_cr0_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             pae_i,
    input  logic             lme_i,
    input  hflags_t          hf_i,
    output logic [REG_W-1:0] new_cr0_o,
    output hflags_t          hf_o,
    output logic             flush_o,
    output logic             fault_o,
    output logic             trunc_o
);

    localparam logic [REG_W-1:0] XLAT_MASK =
        (REG_W'(1) << CR0_PG) | (REG_W'(1) << CR0_WP) | (REG_W'(1) << CR0_PE);
    localparam logic [REG_W-1:0] ET_BIT = REG_W'(1) << CR0_ET;

    logic pg_old, pg_new, enter_lm, leave_lm, accept;

    always_comb begin
        pg_old   = cur_cr0_i[CR0_PG];
        pg_new   = wr_data_i[CR0_PG];
        enter_lm = !pg_old && pg_new && lme_i;
        leave_lm = pg_old && !pg_new && hf_i.lma;
        fault_o  = enter_lm && !pae_i;
        accept   = !fault_o;

        new_cr0_o = cur_cr0_i;
        hf_o      = hf_i;
        flush_o   = 1'b0;
        trunc_o   = 1'b0;

        if (accept) begin
            new_cr0_o  = wr_data_i | ET_BIT;
            flush_o    = |((cur_cr0_i ^ wr_data_i) & XLAT_MASK);
            hf_o.pe    = wr_data_i[CR0_PE];
            if (!wr_data_i[CR0_PE]) begin
                hf_o.addseg = 1'b1;
            end
            {hf_o.ts, hf_o.em, hf_o.mp} = wr_data_i[CR0_TS:CR0_MP];
            if (enter_lm) begin
                hf_o.lma = 1'b1;
            end
            if (leave_lm) begin
                hf_o.lma  = 1'b0;
                hf_o.cs64 = 1'b0;
                trunc_o   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ctl_cr4_update.sv
module ctl_cr4_update
    import ctl_reg_pkg::*;
#(
    parameter bit SSE_EN = 1'b1
) (
    input  logic [REG_W-1:0] cur_cr4_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] new_cr4_o,
    output logic             flush_o
);

    localparam logic [REG_W-1:0] XLAT_MASK =
        (REG_W'(1) << CR4_PGE) | (REG_W'(1) << CR4_PAE) | (REG_W'(1) << CR4_PSE);
    localparam logic [REG_W-1:0] FXS_BIT = REG_W'(1) << CR4_FXS;

    logic [REG_W-1:0] keep_mask;

    generate
        if (SSE_EN) begin : g_sse
            assign keep_mask = '1;
        end else begin : g_nosse
            assign keep_mask = ~FXS_BIT;
        end
    endgenerate

    always_comb begin
        new_cr4_o = wr_data_i & keep_mask;
        flush_o   = |((cur_cr4_i ^ wr_data_i) & XLAT_MASK);
    end

endmodule

// File: rtl/ctl_reg_unit.sv
module ctl_reg_unit
    import ctl_reg_pkg::*;
#(
    parameter bit SSE_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               seg_upd,
    input  logic               seg_cs64,
    input  logic               seg_addseg,
    output logic [REG_W-1:0]   cr0_o,
    output logic [REG_W-1:0]   cr3_o,
    output logic [REG_W-1:0]   cr4_o,
    output logic [REG_W-1:0]   efer_o,
    output logic [HFLAG_W-1:0] hflags_o,
    output logic               tlb_flush_o,
    output logic               lm_fault_o,
    output logic               ip_trunc_o
);

    ctl_state_t st_q, st_d, st_rst;
    ctl_pulse_t pl_q, pl_d, pl_rst;
    hflags_t    hf_seg;

    logic [REG_W-1:0] cr0_new, cr4_new;
    hflags_t          cr0_hf;
    logic             cr0_flush, cr0_fault, cr0_trunc, cr4_flush;

    // segment loader stage, applied ahead of any register write (R13)
    always_comb begin
        hf_seg = st_q.hf;
        if (seg_upd) begin
            if (st_q.hf.lma) begin
                hf_seg.cs64 = seg_cs64;
            end
            if (st_q.hf.pe) begin
                hf_seg.addseg = seg_addseg;
            end
        end
    end

    ctl_cr0_update u_cr0 (
        .cur_cr0_i (st_q.cr0),
        .wr_data_i (wr_data),
        .pae_i     (st_q.cr4[CR4_PAE]),
        .lme_i     (st_q.lme),
        .hf_i      (hf_seg),
        .new_cr0_o (cr0_new),
        .hf_o      (cr0_hf),
        .flush_o   (cr0_flush),
        .fault_o   (cr0_fault),
        .trunc_o   (cr0_trunc)
    );

    ctl_cr4_update #(.SSE_EN(SSE_EN)) u_cr4 (
        .cur_cr4_i (st_q.cr4),
        .wr_data_i (wr_data),
        .new_cr4_o (cr4_new),
        .flush_o   (cr4_flush)
    );

    // reset value built by the same CR0 update logic from an all-zero state (R1)
    logic [REG_W-1:0] rst_cr0;
    hflags_t          rst_hf;
    logic             rst_flush, rst_fault, rst_trunc;

    ctl_cr0_update u_cr0_rst (
        .cur_cr0_i ('0),
        .wr_data_i (CR0_RESET),
        .pae_i     (1'b0),
        .lme_i     (1'b0),
        .hf_i      ('0),
        .new_cr0_o (rst_cr0),
        .hf_o      (rst_hf),
        .flush_o   (rst_flush),
        .fault_o   (rst_fault),
        .trunc_o   (rst_trunc)
    );

    always_comb begin
        st_rst      = '0;
        st_rst.cr0  = rst_cr0;
        st_rst.hf   = rst_hf;
        pl_rst      = '0;
        pl_rst.flush = 1'b0 & rst_flush;
        pl_rst.fault = 1'b0 & rst_fault;
        pl_rst.trunc = 1'b0 & rst_trunc;
    end

    always_comb begin
        st_d    = st_q;
        st_d.hf = hf_seg;
        pl_d    = '0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CR0: begin
                    st_d.cr0     = cr0_new;
                    st_d.hf      = cr0_hf;
                    pl_d.flush   = cr0_flush;
                    pl_d.fault   = cr0_fault;
                    pl_d.trunc   = cr0_trunc;
                end
                SEL_CR3: begin
                    st_d.cr3     = wr_data;
                    pl_d.flush   = st_q.cr0[CR0_PG];
                end
                SEL_CR4: begin
                    st_d.cr4       = cr4_new;
                    st_d.hf.osfxsr = cr4_new[CR4_FXS];
                    pl_d.flush     = cr4_flush;
                end
                SEL_EXT: begin
                    st_d.lme     = wr_data[EXT_LME];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
            pl_q <= pl_rst;
        end else begin
            st_q <= st_d;
            pl_q <= pl_d;
        end
    end

    always_comb begin
        cr0_o            = st_q.cr0;
        cr3_o            = st_q.cr3;
        cr4_o            = st_q.cr4;
        efer_o           = '0;
        efer_o[EXT_LME]  = st_q.lme;
        efer_o[EXT_LMA]  = st_q.hf.lma;
        hflags_o         = st_q.hf;
        tlb_flush_o      = pl_q.flush;
        lm_fault_o       = pl_q.fault;
        ip_trunc_o       = pl_q.trunc;
    end

    // ---------------- assertions ----------------
    p_et_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_o[CR0_ET]);

    p_pe_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hflags_o[0] == cr0_o[CR0_PE]);

    p_addseg_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cr0_o[CR0_PE] |-> hflags_o[1]);

    p_fpu_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hflags_o[4:2] == cr0_o[CR0_TS:CR0_MP]);

    p_lma_needs_pg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        efer_o[EXT_LMA] |-> cr0_o[CR0_PG]);

    p_fault_holds_cr0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lm_fault_o |-> ($stable(cr0_o) && !tlb_flush_o));

    p_cs64_needs_lma_r13: assert property (@(posedge clk) disable iff (!rst_n)
        hflags_o[6] |-> hflags_o[5]);

    p_trunc_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ip_trunc_o |-> (!hflags_o[5] && !hflags_o[6] && !cr0_o[CR0_PG]));

    p_fxs_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hflags_o[7] == cr4_o[CR4_FXS]);

    p_fxs_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !SSE_EN |-> !cr4_o[CR4_FXS]);

    p_pulse_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_flush_o || lm_fault_o || ip_trunc_o) |-> $past(wr_en));

    p_efer_clean_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (efer_o & ~((REG_W'(1) << EXT_LME) | (REG_W'(1) << EXT_LMA))) == '0);

endmodule

// File: tb/ctl_reg_unit_bench.sv
module ctl_reg_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        seg_upd, seg_cs64, seg_addseg;

    logic [31:0] cr0_o, cr3_o, cr4_o, efer_o;
    logic [7:0]  hflags_o;
    logic        tlb_flush_o, lm_fault_o, ip_trunc_o;

    logic [31:0] n_cr0, n_cr3, n_cr4, n_efer;
    logic [7:0]  n_hf;
    logic        n_flush, n_fault, n_trunc;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_reg_unit u_ctl_reg_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .seg_upd(seg_upd), .seg_cs64(seg_cs64), .seg_addseg(seg_addseg),
        .cr0_o(cr0_o), .cr3_o(cr3_o), .cr4_o(cr4_o), .efer_o(efer_o), .hflags_o(hflags_o),
        .tlb_flush_o(tlb_flush_o), .lm_fault_o(lm_fault_o), .ip_trunc_o(ip_trunc_o)
    );

    ctl_reg_unit #(.SSE_EN(1'b0)) u_ctl_reg_unit_nosse (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .seg_upd(seg_upd), .seg_cs64(seg_cs64), .seg_addseg(seg_addseg),
        .cr0_o(n_cr0), .cr3_o(n_cr3), .cr4_o(n_cr4), .efer_o(n_efer), .hflags_o(n_hf),
        .tlb_flush_o(n_flush), .lm_fault_o(n_fault), .ip_trunc_o(n_trunc)
    );

    // reference model state
    logic [31:0] m_cr0, m_cr3, m_cr4;
    logic        m_lme;
    logic [7:0]  m_hf;
    logic        m_flush, m_fault, m_trunc;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_efer();
        logic [31:0] e;
        e = 32'h0;
        e[8]  = m_lme;
        e[10] = m_hf[5];
        return e;
    endfunction

    task automatic model_reset();
        m_cr0 = 32'h6000_0010; m_cr3 = 0; m_cr4 = 0; m_lme = 0;
        m_hf = 8'h02; m_flush = 0; m_fault = 0; m_trunc = 0;
    endtask

    task automatic model_apply(input logic we, input logic [1:0] sel, input logic [31:0] d,
                               input logic su, input logic scs, input logic sadd);
        logic enter, leave;
        m_flush = 0; m_fault = 0; m_trunc = 0;
        if (su) begin
            if (m_hf[5]) m_hf[6] = scs;
            if (m_hf[0]) m_hf[1] = sadd;
        end
        if (we) begin
            case (sel)
                2'd0: begin
                    enter = !m_cr0[31] && d[31] && m_lme;
                    leave = m_cr0[31] && !d[31] && m_hf[5];
                    if (enter && !m_cr4[5]) begin
                        m_fault = 1;
                    end else begin
                        m_flush = ((m_cr0 ^ d) & 32'h8001_0001) != 0;
                        m_cr0 = d | 32'h10;
                        m_hf[0] = d[0];
                        if (!d[0]) m_hf[1] = 1;
                        m_hf[4:2] = d[3:1];
                        if (enter) m_hf[5] = 1;
                        if (leave) begin m_hf[5] = 0; m_hf[6] = 0; m_trunc = 1; end
                    end
                end
                2'd1: begin m_cr3 = d; m_flush = m_cr0[31]; end
                2'd2: begin
                    m_flush = ((m_cr4 ^ d) & 32'h0000_00B0) != 0;
                    m_cr4 = d; m_hf[7] = d[9];
                end
                default: m_lme = d[8];
            endcase
        end
    endtask

    task automatic compare_all();
        chk(cr0_o == m_cr0, "R2/R3 cr0", cr0_o, m_cr0);
        chk(cr3_o == m_cr3, "R11 cr3", cr3_o, m_cr3);
        chk(cr4_o == m_cr4, "R10 cr4", cr4_o, m_cr4);
        chk(efer_o == m_efer(), "R14 efer", efer_o, m_efer());
        chk(hflags_o[1:0] == m_hf[1:0], "R8 pe/addseg", {30'd0, hflags_o[1:0]}, {30'd0, m_hf[1:0]});
        chk(hflags_o[4:2] == m_hf[4:2], "R9 mp/em/ts", {29'd0, hflags_o[4:2]}, {29'd0, m_hf[4:2]});
        chk(hflags_o[5] == m_hf[5], "R5 lma", {31'd0, hflags_o[5]}, {31'd0, m_hf[5]});
        chk(hflags_o[6] == m_hf[6], "R13 cs64", {31'd0, hflags_o[6]}, {31'd0, m_hf[6]});
        chk(hflags_o[7] == m_hf[7], "R10 osfxsr", {31'd0, hflags_o[7]}, {31'd0, m_hf[7]});
        chk(tlb_flush_o == m_flush, "R4 flush", {31'd0, tlb_flush_o}, {31'd0, m_flush});
        chk(lm_fault_o == m_fault, "R6 fault", {31'd0, lm_fault_o}, {31'd0, m_fault});
        chk(ip_trunc_o == m_trunc, "R7 trunc", {31'd0, ip_trunc_o}, {31'd0, m_trunc});
        chk(!n_cr4[9] && !n_hf[7], "R10 nosse mask", {22'd0, n_cr4[9], 8'd0, n_hf[7]}, 32'h0);
    endtask

    // drive one cycle at the falling edge, model it, compare at the next falling edge
    task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] d,
                        input logic su = 0, input logic scs = 0, input logic sadd = 0);
        wr_en = we; wr_sel = sel; wr_data = d;
        seg_upd = su; seg_cs64 = scs; seg_addseg = sadd;
        @(negedge clk);
        model_apply(we, sel, d, su, scs, sadd);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        seg_upd = 0; seg_cs64 = 0; seg_addseg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        @(negedge clk);
        // R1 reset state
        chk(cr0_o == 32'h6000_0010, "R1 reset cr0", cr0_o, 32'h6000_0010);
        chk(hflags_o == 8'h02, "R1 reset hflags", {24'd0, hflags_o}, 32'h02);
        chk(!tlb_flush_o && !lm_fault_o && !ip_trunc_o, "R1 reset pulses",
            {29'd0, tlb_flush_o, lm_fault_o, ip_trunc_o}, 32'h0);
        compare_all();

        // directed corner cases
        step(1, 2'd0, 32'h0000_000B);                  // PE set, MP/TS: flush R4
        chk(tlb_flush_o && hflags_o[0], "R4 pe change flush", {31'd0, tlb_flush_o}, 32'h1);
        chk(cr0_o == 32'h0000_001B, "R3 ET forced", cr0_o, 32'h0000_001B);
        step(0, 2'd0, 32'h0);
        chk(!tlb_flush_o, "R12 pulse ends", {31'd0, tlb_flush_o}, 32'h0);
        step(1, 2'd3, 32'hFFFF_FFFF);                  // LME set, LMA not writable
        chk(efer_o == 32'h100, "R14 only LME", efer_o, 32'h100);
        step(1, 2'd0, 32'h8000_0001);                  // entry with PAE clear
        chk(lm_fault_o && cr0_o == 32'h1B, "R6 rejected", cr0_o, 32'h1B);
        step(1, 2'd2, 32'h0000_0220);                  // PAE + OSFXSR
        chk(tlb_flush_o && hflags_o[7], "R10 pae flush", {31'd0, tlb_flush_o}, 32'h1);
        step(1, 2'd0, 32'h8000_0001);                  // entry accepted
        chk(efer_o[10] && hflags_o[5], "R5 lma set", efer_o, 32'h500);
        step(0, 2'd0, 32'h0, 1, 1, 0);                 // cs64 and addseg via loader
        chk(hflags_o[6] && !hflags_o[1], "R13 loader update", {24'd0, hflags_o}, 32'h0);
        step(1, 2'd1, 32'h0012_3000);                  // CR3 with paging
        chk(tlb_flush_o, "R11 cr3 flush on", {31'd0, tlb_flush_o}, 32'h1);
        step(1, 2'd0, 32'h0000_0001);                  // leave long mode
        chk(ip_trunc_o && !hflags_o[5] && !hflags_o[6], "R7 exit", {24'd0, hflags_o}, 32'h01);
        step(1, 2'd1, 32'h0045_6000);                  // CR3 paging off
        chk(!tlb_flush_o && cr3_o == 32'h0045_6000, "R11 cr3 no flush", cr3_o, 32'h0045_6000);
        step(1, 2'd0, 32'h0000_0001);                  // same translation bits
        chk(!tlb_flush_o, "R4 no flush", {31'd0, tlb_flush_o}, 32'h0);
        step(1, 2'd0, 32'h0000_0000);                  // real mode
        step(0, 2'd0, 32'h0, 1, 1, 0);                 // ignored in real mode, no LMA
        chk(hflags_o[1] && !hflags_o[6], "R13 ignored", {24'd0, hflags_o}, 32'h02);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] d;
            logic [1:0]  sel;
            d   = $urandom;
            sel = 2'($urandom_range(0, 3));
            if (sel == 2'd2 && ($urandom_range(0, 1) == 1)) d[5] = 1'b1;
            step(($urandom_range(0, 3) != 0), sel, d,
                 ($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule